// File: doc/BRIEF.md
# Hardware-Triggered ADC Step Sequencer

This block is the control sequencer in front of an analog-to-digital converter. Software programs a bank of conversion steps. Each step has a 2-bit mode and one enable bit, and all enable bits sit in a single step-enable register. The sequencer scans the enabled steps in ascending index order. For each step it asks an abstract converter for one sample, waits for the converter's done handshake, and pushes the sample into a result FIFO. The sample can be tagged with the index of the step that produced it.

A step runs in one of two ways:
- **Software-started steps** run as soon as they are enabled while the global enable is high.
- **Hardware-synchronized steps** wait for a start event. A trigger multiplexer picks the event from several sources (a timer overflow pending line on select 2, among others). A mapping control can instead take the event from a dedicated external trigger pin.

**Enable bits and global enable.**
- A one-shot step has its enable bit cleared by the sequencer once its result is written.
- A continuous step keeps its enable bit. It runs again on every later pass until software drops the global enable.
- Dropping the global enable discards any pending event. Hardware steps then need a fresh event after re-enable.

**State machine.** The sequencer has four states: `ST_IDLE`, `ST_SCAN`, `ST_REQ` and `ST_WRITE`.

| From | To | Condition |
|---|---|---|
| `ST_IDLE` | `ST_SCAN` | A pass starts: a hardware event is pending, or an enabled software step exists |
| `ST_SCAN` | `ST_REQ` | The current step is eligible for this pass |
| `ST_SCAN` | `ST_SCAN` | The current step is not eligible; advance the index |
| `ST_SCAN` | `ST_IDLE` | The last index is not eligible (end of pass) |
| `ST_REQ` | `ST_WRITE` | `conv_done` arrives |
| `ST_WRITE` | `ST_SCAN` | Not the last index; advance the index |
| `ST_WRITE` | `ST_IDLE` | Last index (end of pass) |
| `ST_SCAN`, `ST_REQ`, `ST_WRITE` | `ST_IDLE` | `adc_en` is low |

Top module: `adc_step_seq`

## Requirements
- R1: Each step has a 2-bit mode. Bit 1 set means hardware-synchronized and bit 1 clear means software-started. Bit 0 set means continuous and bit 0 clear means one-shot. So 00 is software one-shot, 01 software continuous, 10 hardware one-shot and 11 hardware continuous. The mode is written with `cfg_we`, `cfg_idx` and `cfg_mode`.
- R2: After a one-shot step's result is written, its bit in `step_en` reads 0. A continuous step's bit is never cleared by the sequencer. A write on `en_we` loads all enable bits from `en_wdata` and takes priority over a clear in the same cycle.
- R3: Within a pass, eligible steps are converted in ascending index order. A pass with no eligible step issues no request and writes nothing.
- R4: While `adc_en` is high, any enabled software step starts a pass without any event. Such a pass converts only software steps, and an enabled software continuous step makes passes repeat back to back. A hardware-started pass converts every enabled step.
- R5: With `hw_evt_map`=0, the start event is `evt_src[trig_sel]`, and index 2 is the timer overflow pending line. Unselected sources and `ext_trig` have no effect. With `hw_evt_map`=1, the start event is `ext_trig` and `evt_src` has no effect.
- R6: The chosen event goes through a 2-flop synchronizer and only its rising edge counts. Each edge starts at most one hardware pass. An edge arriving while a hardware-started pass is running is ignored.
- R7: With `adc_en` low, the sequencer returns to idle on the next clock, drops any pending event, and ignores events. After re-enable, hardware steps do not run until a new rising edge arrives.
- R8: A result word is {tag, data}. The tag occupies the top $clog2(NSTEP) bits and equals the step index when `tag_en`=1, and 0 otherwise. The data occupies the low DW bits.
- R9: `fifo_rdata` shows the oldest word. A `fifo_rd` pulse pops it. `fifo_count` tracks the stored words and `fifo_empty` is high at zero.
- R10: A result arriving while the FIFO holds FIFO_DEPTH words is dropped, `fifo_count` stays at FIFO_DEPTH, and `fifo_ovf` sets. `fifo_ovf` stays set until `adc_en` goes low.
- R11: For each eligible step, exactly one conversion is requested. `conv_req` stays high, with `conv_chan` equal to the step index, until `conv_done`. `conv_data` is captured on that cycle.
- R12: After reset, all enable bits are 0, the FIFO is empty, `fifo_ovf` is 0 and `conv_req` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| adc_en | input | 1 | Global converter enable |
| tag_en | input | 1 | Put step index into result words |
| hw_evt_map | input | 1 | 1: start event from ext_trig; 0: from trigger mux |
| trig_sel | input | SELW | Trigger mux select |
| evt_src | input | NSRC | Candidate hardware event sources (bit 2 = timer overflow) |
| ext_trig | input | 1 | Dedicated external trigger pin |
| cfg_we | input | 1 | Step mode write strobe |
| cfg_idx | input | IDW | Step index for mode write |
| cfg_mode | input | 2 | Mode value to write |
| en_we | input | 1 | Step-enable register write strobe |
| en_wdata | input | NSTEP | New step-enable value |
| step_en | output | NSTEP | Current step-enable register |
| conv_req | output | 1 | Conversion request to converter |
| conv_chan | output | IDW | Step index being converted |
| conv_done | input | 1 | Converter done pulse |
| conv_data | input | DW | Converter sample, valid with conv_done |
| fifo_rd | input | 1 | Pop the oldest result |
| fifo_rdata | output | IDW+DW | Oldest result word |
| fifo_count | output | CW | Words held in the FIFO |
| fifo_empty | output | 1 | FIFO holds no word |
| fifo_full | output | 1 | FIFO holds FIFO_DEPTH words |
| fifo_ovf | output | 1 | Sticky overflow flag |

## Verification
The bench goes after four corner cases, each with the failure it would expose:

| Corner case | What a wrong design would do |
|---|---|
| A second edge arrives during a slow hardware pass | Queue the edge and run an extra pass, so the FIFO would hold eight words instead of four |
| An event arrives while disabled, then the block is re-enabled | Run hardware steps with no fresh edge |
| A hardware event fires with no step enabled | Issue a stray request |
| A continuous software step overfills the FIFO | Overwrite old words, or let the count exceed the depth |

Random masks that mix one-shot and continuous hardware steps across all trigger sources check two things. First, a second pass converts only the continuous survivors. Second, an unselected source or pin starts nothing.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    typedef enum logic [1:0] {
        MODE_SW_ONCE = 2'b00,
        MODE_SW_LOOP = 2'b01,
        MODE_HW_ONCE = 2'b10,
        MODE_HW_LOOP = 2'b11
    } step_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SCAN  = 2'd1,
        ST_REQ   = 2'd2,
        ST_WRITE = 2'd3
    } seq_state_e;

    function automatic logic mode_is_hw(step_mode_e m);
        return (m == MODE_HW_ONCE) || (m == MODE_HW_LOOP);
    endfunction

    function automatic logic mode_is_loop(step_mode_e m);
        return (m == MODE_SW_LOOP) || (m == MODE_HW_LOOP);
    endfunction

endpackage

// File: rtl/adc_seq_trig.sv
module adc_seq_trig #(
    parameter int NSRC    = 4,
    parameter int SYNC_N  = 2,
    localparam int SELW   = (NSRC > 1) ? $clog2(NSRC) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            hw_evt_map,
    input  logic [SELW-1:0] trig_sel,
    input  logic [NSRC-1:0] evt_src,
    input  logic            ext_trig,
    output logic            evt_pulse
);

    localparam int NPAD = 1 << SELW;

    logic mux_out;
    logic chosen;
    logic [SYNC_N:0] sync_q;

    generate
        if (NSRC == NPAD) begin : g_full
            assign mux_out = evt_src[trig_sel];
        end else begin : g_pad
            logic [NPAD-1:0] padded;
            assign padded  = {{(NPAD-NSRC){1'b0}}, evt_src};
            assign mux_out = padded[trig_sel];
        end
    endgenerate

    assign chosen = hw_evt_map ? ext_trig : mux_out;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
        end else begin
            sync_q <= {sync_q[SYNC_N-1:0], chosen};
        end
    end

    assign evt_pulse = sync_q[SYNC_N-1] & ~sync_q[SYNC_N];

    // R6
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt_pulse |=> !evt_pulse);

endmodule

// File: rtl/adc_seq_steps.sv
module adc_seq_steps
    import adc_seq_pkg::*;
#(
    parameter int NSTEP = 8,
    localparam int IDW  = (NSTEP > 1) ? $clog2(NSTEP) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [IDW-1:0]   cfg_idx,
    input  logic [1:0]       cfg_mode,
    input  logic             en_we,
    input  logic [NSTEP-1:0] en_wdata,
    input  logic             retire_vld,
    input  logic [IDW-1:0]   retire_idx,
    output logic [NSTEP-1:0] en_q,
    output logic [NSTEP-1:0] hw_mask
);

    step_mode_e       mode_q [NSTEP];
    logic [NSTEP-1:0] loop_mask;

    generate
        for (genvar g = 0; g < NSTEP; g++) begin : g_step
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    mode_q[g] <= MODE_SW_ONCE;
                end else if (cfg_we && (cfg_idx == IDW'(g))) begin
                    mode_q[g] <= step_mode_e'(cfg_mode);
                end
            end

            assign hw_mask[g]   = mode_is_hw(mode_q[g]);
            assign loop_mask[g] = mode_is_loop(mode_q[g]);

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    en_q[g] <= 1'b0;
                end else if (en_we) begin
                    en_q[g] <= en_wdata[g];
                end else if (retire_vld && (retire_idx == IDW'(g)) && !loop_mask[g]) begin
                    en_q[g] <= 1'b0;
                end
            end
        end
    endgenerate

    // R2
    oneshot_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (retire_vld && !en_we && !loop_mask[retire_idx]) |=> !en_q[$past(retire_idx)]);

    // R2
    loop_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (retire_vld && !en_we && !cfg_we && loop_mask[retire_idx] && en_q[retire_idx])
        |=> en_q[$past(retire_idx)]);

endmodule

// File: rtl/adc_seq_fifo.sv
module adc_seq_fifo #(
    parameter int WW    = 15,
    parameter int DEPTH = 8,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [WW-1:0] wdata,
    input  logic          pop,
    input  logic          clr_ovf,
    output logic [WW-1:0] rdata,
    output logic [CW-1:0] count,
    output logic          full,
    output logic          empty,
    output logic          ovf
);

    logic [WW-1:0] mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic          do_push, do_pop, drop;

    assign full    = (count == CW'(DEPTH));
    assign empty   = (count == '0);
    assign do_pop  = pop && !empty;
    assign do_push = push && !full;
    assign drop    = push && full;
    assign rdata   = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wr_ptr] <= wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
            ovf    <= 1'b0;
        end else begin
            if (do_push) begin
                wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + AW'(1);
            end
            if (do_pop) begin
                rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + AW'(1);
            end
            unique case ({do_push, do_pop})
                2'b10:   count <= count + CW'(1);
                2'b01:   count <= count - CW'(1);
                default: count <= count;
            endcase
            if (clr_ovf) begin
                ovf <= 1'b0;
            end else if (drop) begin
                ovf <= 1'b1;
            end
        end
    end

    // R10
    drop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop) |=> (count == $past(count)));

    // R10
    ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !clr_ovf) |=> ovf);

    // R9
    pop_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && empty && !push) |=> empty);

endmodule

// File: rtl/adc_step_seq.sv
module adc_step_seq
    import adc_seq_pkg::*;
#(
    parameter int NSTEP      = 8,
    parameter int NSRC       = 4,
    parameter int DW         = 12,
    parameter int FIFO_DEPTH = 8,
    localparam int IDW       = (NSTEP > 1) ? $clog2(NSTEP) : 1,
    localparam int SELW      = (NSRC > 1) ? $clog2(NSRC) : 1,
    localparam int WW        = IDW + DW,
    localparam int CW        = $clog2(FIFO_DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adc_en,
    input  logic             tag_en,
    input  logic             hw_evt_map,
    input  logic [SELW-1:0]  trig_sel,
    input  logic [NSRC-1:0]  evt_src,
    input  logic             ext_trig,
    input  logic             cfg_we,
    input  logic [IDW-1:0]   cfg_idx,
    input  logic [1:0]       cfg_mode,
    input  logic             en_we,
    input  logic [NSTEP-1:0] en_wdata,
    output logic [NSTEP-1:0] step_en,
    output logic             conv_req,
    output logic [IDW-1:0]   conv_chan,
    input  logic             conv_done,
    input  logic [DW-1:0]    conv_data,
    input  logic             fifo_rd,
    output logic [WW-1:0]    fifo_rdata,
    output logic [CW-1:0]    fifo_count,
    output logic             fifo_empty,
    output logic             fifo_full,
    output logic             fifo_ovf
);

    seq_state_e       state_q, state_d;
    logic [IDW-1:0]   idx_q;
    logic             hw_pass_q;
    logic             hw_pend_q;
    logic [DW-1:0]    data_q;
    logic [NSTEP-1:0] hw_mask;
    logic [NSTEP-1:0] elig;
    logic             evt_pulse;
    logic             sw_ready;
    logic             idx_last;
    logic             start_pass;
    logic             advance;
    logic             wr_result;
    logic             hw_busy;
    logic [WW-1:0]    result_word;

    adc_seq_trig #(
        .NSRC   (NSRC),
        .SYNC_N (2)
    ) u_trig (
        .clk        (clk),
        .rst_n      (rst_n),
        .hw_evt_map (hw_evt_map),
        .trig_sel   (trig_sel),
        .evt_src    (evt_src),
        .ext_trig   (ext_trig),
        .evt_pulse  (evt_pulse)
    );

    adc_seq_steps #(
        .NSTEP (NSTEP)
    ) u_steps (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_we     (cfg_we),
        .cfg_idx    (cfg_idx),
        .cfg_mode   (cfg_mode),
        .en_we      (en_we),
        .en_wdata   (en_wdata),
        .retire_vld (wr_result),
        .retire_idx (idx_q),
        .en_q       (step_en),
        .hw_mask    (hw_mask)
    );

    assign result_word = {(tag_en ? idx_q : {IDW{1'b0}}), data_q};

    adc_seq_fifo #(
        .WW    (WW),
        .DEPTH (FIFO_DEPTH)
    ) u_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .push    (wr_result),
        .wdata   (result_word),
        .pop     (fifo_rd),
        .clr_ovf (!adc_en),
        .rdata   (fifo_rdata),
        .count   (fifo_count),
        .full    (fifo_full),
        .empty   (fifo_empty),
        .ovf     (fifo_ovf)
    );

    // Pass eligibility: software steps always, hardware steps only in an event-started pass
    assign sw_ready = |(step_en & ~hw_mask);
    assign elig     = step_en & (hw_pass_q ? {NSTEP{1'b1}} : ~hw_mask);
    assign idx_last = (idx_q == IDW'(NSTEP - 1));
    assign hw_busy  = (state_q != ST_IDLE) && hw_pass_q;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (adc_en && (hw_pend_q || sw_ready)) begin
                    state_d = ST_SCAN;
                end
            end
            ST_SCAN: begin
                if (!adc_en) begin
                    state_d = ST_IDLE;
                end else if (elig[idx_q]) begin
                    state_d = ST_REQ;
                end else if (idx_last) begin
                    state_d = ST_IDLE;
                end
            end
            ST_REQ: begin
                if (!adc_en) begin
                    state_d = ST_IDLE;
                end else if (conv_done) begin
                    state_d = ST_WRITE;
                end
            end
            ST_WRITE: begin
                if (!adc_en || idx_last) begin
                    state_d = ST_IDLE;
                end else begin
                    state_d = ST_SCAN;
                end
            end
        endcase
    end

    // Output decode
    always_comb begin
        start_pass = 1'b0;
        advance    = 1'b0;
        conv_req   = 1'b0;
        wr_result  = 1'b0;
        unique case (state_q)
            ST_IDLE:  start_pass = adc_en && (hw_pend_q || sw_ready);
            ST_SCAN:  advance    = adc_en && !elig[idx_q] && !idx_last;
            ST_REQ:   conv_req   = 1'b1;
            ST_WRITE: begin
                wr_result = 1'b1;
                advance   = adc_en && !idx_last;
            end
        endcase
    end

    assign conv_chan = idx_q;

    // Datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q     <= '0;
            hw_pass_q <= 1'b0;
            hw_pend_q <= 1'b0;
            data_q    <= '0;
        end else begin
            if (start_pass) begin
                idx_q     <= '0;
                hw_pass_q <= hw_pend_q;
            end else if (advance) begin
                idx_q <= idx_q + IDW'(1);
            end

            if (!adc_en) begin
                hw_pend_q <= 1'b0;
            end else if (start_pass && hw_pend_q) begin
                hw_pend_q <= 1'b0;
            end else if (evt_pulse && !hw_busy) begin
                hw_pend_q <= 1'b1;
            end

            if ((state_q == ST_REQ) && conv_done) begin
                data_q <= conv_data;
            end
        end
    end

    // R7
    idle_on_disable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !adc_en |=> (state_q == ST_IDLE));

    // R7
    pend_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !adc_en |=> !hw_pend_q);

    // R11
    write_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WRITE) |-> ($past(state_q) == ST_REQ) && $past(conv_done));

    // R11
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_req && !conv_done && adc_en) |=> conv_req && $stable(conv_chan));

    // R3
    scan_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_SCAN) && ($past(state_q) == ST_WRITE)) |-> (idx_q > $past(idx_q)));

    // R6
    hw_edge_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hw_busy && !hw_pend_q && adc_en) |=> !hw_pend_q || ($past(state_q) != ST_IDLE && !$past(hw_busy)) || !$past(hw_busy));

endmodule

// File: tb/adc_step_seq_tb.sv
`timescale 1ns/1ps
module adc_step_seq_tb;

    localparam int NSTEP = 8;
    localparam int DW    = 12;
    localparam int DEPTH = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        adc_en = 1'b0;
    logic        tag_en = 1'b1;
    logic        hw_evt_map = 1'b0;
    logic [1:0]  trig_sel = 2'd2;
    logic [3:0]  evt_src = '0;
    logic        ext_trig = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_idx = '0;
    logic [1:0]  cfg_mode = '0;
    logic        en_we = 1'b0;
    logic [7:0]  en_wdata = '0;
    logic [7:0]  step_en;
    logic        conv_req;
    logic [2:0]  conv_chan;
    logic        conv_done = 1'b0;
    logic [11:0] conv_data = '0;
    logic        fifo_rd = 1'b0;
    logic [14:0] fifo_rdata;
    logic [3:0]  fifo_count;
    logic        fifo_empty, fifo_full, fifo_ovf;

    int checks = 0;
    int failures = 0;
    int nconv = 0;
    int npop = 0;
    int conv_lat = 1;
    bit tag_on = 1'b1;
    int exp_q[$];

    always #2 clk = ~clk;

    adc_step_seq u_dut (
        .clk(clk), .rst_n(rst_n), .adc_en(adc_en), .tag_en(tag_en),
        .hw_evt_map(hw_evt_map), .trig_sel(trig_sel), .evt_src(evt_src),
        .ext_trig(ext_trig), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
        .cfg_mode(cfg_mode), .en_we(en_we), .en_wdata(en_wdata),
        .step_en(step_en), .conv_req(conv_req), .conv_chan(conv_chan),
        .conv_done(conv_done), .conv_data(conv_data), .fifo_rd(fifo_rd),
        .fifo_rdata(fifo_rdata), .fifo_count(fifo_count),
        .fifo_empty(fifo_empty), .fifo_full(fifo_full), .fifo_ovf(fifo_ovf)
    );

    function automatic logic [11:0] mix(input int id, input int k);
        return 12'((id * 397 + k * 29 + 5) & 12'hFFF);
    endfunction

    function automatic logic [14:0] exp_word(input int id, input int k, input bit tg);
        logic [2:0] t;
        t = tg ? 3'(id) : 3'd0;
        return {t, mix(id, k)};
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Converter model: answers each request after conv_lat cycles
    initial begin
        forever begin
            @(negedge clk);
            if (conv_req) begin
                int ch;
                ch = int'(conv_chan);
                if (conv_lat > 1) repeat (conv_lat - 1) @(negedge clk);
                conv_done = 1'b1;
                conv_data = mix(ch, nconv);
                nconv++;
                @(negedge clk);
                conv_done = 1'b0;
            end
        end
    end

    task automatic set_mode(input int idx, input int mode);
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = 3'(idx); cfg_mode = 2'(mode);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic set_en(input logic [7:0] m);
        @(negedge clk);
        en_we = 1'b1; en_wdata = m;
        @(negedge clk);
        en_we = 1'b0;
    endtask

    task automatic pulse_ev(input bit ext, input int sel);
        @(negedge clk);
        if (ext) ext_trig = 1'b1; else evt_src[sel] = 1'b1;
        repeat (3) @(negedge clk);
        ext_trig = 1'b0; evt_src = '0;
    endtask

    task automatic predict(input logic [7:0] m);
        for (int i = 0; i < NSTEP; i++) if (m[i]) exp_q.push_back(i);
    endtask

    task automatic drain(input string req);
        @(negedge clk);
        while (exp_q.size() > 0) begin
            int id;
            logic [14:0] w;
            id = exp_q.pop_front();
            w  = exp_word(id, npop, tag_on);
            check(!fifo_empty, req, "fifo has word", int'(fifo_empty), 0);
            check(fifo_rdata == w, req, "result word", int'(fifo_rdata), int'(w));
            fifo_rd = 1'b1;
            @(negedge clk);
            fifo_rd = 1'b0;
            @(negedge clk);
            npop++;
        end
        check(fifo_empty, req, "fifo empty after drain", int'(fifo_count), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int n0;
        void'($urandom(32'd4711));
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R12 reset state
        check(step_en == 8'h00, "R12", "step_en", int'(step_en), 0);
        check(fifo_count == 0 && fifo_empty, "R12", "fifo_count", int'(fifo_count), 0);
        check(!fifo_ovf, "R12", "fifo_ovf", int'(fifo_ovf), 0);
        check(!conv_req, "R12", "conv_req", int'(conv_req), 0);

        // R1 R2 R4 R11: software one-shot steps 1,3,4
        adc_en = 1'b1;
        set_mode(1, 0); set_mode(3, 0); set_mode(4, 0);
        n0 = nconv;
        set_en(8'b0001_1010);
        predict(8'b0001_1010);
        repeat (100) @(negedge clk);
        check(step_en == 8'h00, "R2", "one-shot enables cleared", int'(step_en), 0);
        check(fifo_count == 3, "R9", "fifo_count", int'(fifo_count), 3);
        check(nconv - n0 == 3, "R11", "one request per step", nconv - n0, 3);
        drain("R3");

        // R4 R5: hardware continuous steps 0,2 via timer overflow (select 2)
        set_mode(0, 3); set_mode(2, 3);
        set_en(8'b0000_0101);
        repeat (40) @(negedge clk);
        check(fifo_count == 0, "R4", "hw steps wait for event", int'(fifo_count), 0);
        pulse_ev(1'b0, 1);
        repeat (60) @(negedge clk);
        check(fifo_count == 0, "R5", "unselected source ignored", int'(fifo_count), 0);
        pulse_ev(1'b1, 0);
        repeat (60) @(negedge clk);
        check(fifo_count == 0, "R5", "ext pin ignored when mux mapped", int'(fifo_count), 0);
        pulse_ev(1'b0, 2);
        repeat (80) @(negedge clk);
        predict(8'b0000_0101);
        check(step_en == 8'h05, "R2", "continuous enables kept", int'(step_en), 5);
        drain("R5");
        pulse_ev(1'b0, 2);
        repeat (80) @(negedge clk);
        predict(8'b0000_0101);
        drain("R6");

        // R5 external pin mapping
        hw_evt_map = 1'b1;
        pulse_ev(1'b0, 2);
        repeat (60) @(negedge clk);
        check(fifo_count == 0, "R5", "mux ignored when pin mapped", int'(fifo_count), 0);
        pulse_ev(1'b1, 0);
        repeat (80) @(negedge clk);
        predict(8'b0000_0101);
        drain("R5");
        hw_evt_map = 1'b0;

        // R8 tag disabled
        tag_en = 1'b0; tag_on = 1'b0;
        pulse_ev(1'b0, 2);
        repeat (80) @(negedge clk);
        predict(8'b0000_0101);
        drain("R8");
        tag_en = 1'b1; tag_on = 1'b1;

        // R7 disable, event while disabled, re-enable
        adc_en = 1'b0;
        pulse_ev(1'b0, 2);
        repeat (20) @(negedge clk);
        adc_en = 1'b1;
        repeat (60) @(negedge clk);
        check(fifo_count == 0, "R7", "no pass without fresh edge", int'(fifo_count), 0);
        pulse_ev(1'b0, 2);
        repeat (80) @(negedge clk);
        predict(8'b0000_0101);
        drain("R7");

        // R6 edge during a running hardware pass is ignored
        set_en(8'h00);
        for (int i = 0; i < 4; i++) set_mode(i, 3);
        set_en(8'h0F);
        conv_lat = 12;
        pulse_ev(1'b0, 2);
        repeat (10) @(negedge clk);
        pulse_ev(1'b0, 2);
        repeat (300) @(negedge clk);
        check(fifo_count == 4, "R6", "single pass for two edges", int'(fifo_count), 4);
        predict(8'h0F);
        drain("R6");
        conv_lat = 1;

        // R3 empty hardware pass
        set_en(8'h00);
        n0 = nconv;
        pulse_ev(1'b0, 2);
        repeat (60) @(negedge clk);
        check(nconv == n0, "R3", "empty pass issues no request", nconv - n0, 0);
        check(fifo_count == 0, "R3", "empty pass writes nothing", int'(fifo_count), 0);

        // Random hardware masks, modes and trigger sources (R1 R2 R3 R5)
        for (int it = 0; it < 12; it++) begin
            logic [7:0] m, lp;
            bit ext;
            int sel;
            m  = 8'($urandom_range(1, 255));
            lp = '0;
            set_en(8'h00);
            for (int i = 0; i < NSTEP; i++) begin
                bit loop_b;
                loop_b = 1'($urandom % 2);
                lp[i] = loop_b;
                set_mode(i, loop_b ? 3 : 2);
            end
            set_en(m);
            conv_lat = $urandom_range(1, 4);
            tag_on = 1'($urandom % 2);
            tag_en = tag_on;
            ext = 1'($urandom % 2);
            sel = $urandom_range(0, 3);
            hw_evt_map = ext;
            trig_sel = 2'(sel);
            pulse_ev(ext, sel);
            repeat (150) @(negedge clk);
            predict(m);
            drain("R1");
            check(step_en == (m & lp), "R2", "enables after pass", int'(step_en), int'(m & lp));
            pulse_ev(ext, sel);
            repeat (150) @(negedge clk);
            predict(m & lp);
            drain("R3");
        end
        conv_lat = 1; tag_on = 1'b1; tag_en = 1'b1;
        hw_evt_map = 1'b0; trig_sel = 2'd2;

        // R10 overflow with a software continuous step
        set_en(8'h00);
        set_mode(5, 1);
        repeat (4) @(negedge clk);
        npop = nconv;
        set_en(8'h20);
        repeat (200) @(negedge clk);
        check(fifo_count == DEPTH, "R10", "count saturates", int'(fifo_count), DEPTH);
        check(fifo_full, "R10", "fifo_full", int'(fifo_full), 1);
        check(fifo_ovf, "R10", "overflow flag set", int'(fifo_ovf), 1);
        check(step_en == 8'h20, "R4", "sw continuous enable kept", int'(step_en), 32);
        adc_en = 1'b0;
        repeat (3) @(negedge clk);
        check(!fifo_ovf, "R10", "overflow cleared by disable", int'(fifo_ovf), 0);
        check(!conv_req, "R7", "no request while disabled", int'(conv_req), 0);
        repeat (30) @(negedge clk);
        check(fifo_count == DEPTH, "R10", "stored words kept", int'(fifo_count), DEPTH);
        for (int i = 0; i < DEPTH; i++) exp_q.push_back(5);
        drain("R10");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule